// File: doc/BRIEF.md
# Serial Span-Select DAC Loader

This block is the digital front end of a 16-bit multiplying digital-to-analog converter whose output span is chosen in software. A host lowers an active-low select/load line, shifts command and data bits in most-significant bit first on a serial clock, then raises the line. On that rising edge the block decodes the last 24 bits received. A 4-bit command sits in the top nibble, then four unused bits, then a 16-bit code in the low half. The block then updates its registered span and code.

The serial clock, data and select inputs are sampled by the block's own clock. A serial-clock edge counts when the block sees the serial clock low in one cycle and high in the next. The outputs are the registered DAC code, the span selection, and the ideal output voltage in millivolts. That voltage is derived from the code and span with integer arithmetic and serves as a checking aid.

Top module: `dac_span_loader`

## Requirements
- R1: After reset the span is unipolar 0 V to +10 V (span_sel = 0), dac_code is 0x0000 and ideal_mv is 0.
- R2: Bits are shifted in MSB first on each rising serial-clock edge while sel_ld is low. Frame bits [23:20] form the command and bits [15:0] form the data code. Bits [19:16] are ignored.
- R3: A frame longer than 24 bits, such as 32 bits, is accepted, and only the final 24 bits shifted in are decoded.
- R4: dac_code, span_sel and ideal_mv do not change while sel_ld is low. They take their new values on the first clock edge at which sel_ld is sampled high.
- R5: Command 4'b1001 selects span_sel = 0 (0 V to +10 V) and loads the data code.
- R6: Command 4'b1010 selects span_sel = 1 (−5 V to +5 V) and loads the data code.
- R7: Command 4'b1011 selects span_sel = 2 (−10 V to +10 V) and loads the data code.
- R8: Command 4'b0010 loads the data code and keeps the current span.
- R9: Any other command leaves both span and code unchanged.
- R10: A frame of fewer than 24 bits leaves both span and code unchanged.
- R11: Serial-clock edges while sel_ld is high are ignored and do not count toward the next frame.
- R12: ideal_mv = span_min + floor(code × span_width / 65536). The minimum and width are 0/10000 for span 0, −5000/10000 for span 1 and −10000/20000 for span 2. Bipolar codes are offset binary, so 0x8000 gives 0 mV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial clock; rising edge shifts one bit |
| ser_dat | input | 1 | Serial data, MSB first |
| sel_ld | input | 1 | Active-low select; rising edge loads the frame |
| dac_code | output | 16 | Registered DAC data code |
| span_sel | output | 2 | Registered span: 0 = 0..+10 V, 1 = ±5 V, 2 = ±10 V |
| ideal_mv | output | 16 | Signed ideal output in millivolts |

## Verification
The register that holds span and code is written on the clock edge where sel_ld is first sampled high. ideal_mv follows it combinationally, so all three results are due one edge after the bench raises sel_ld. The bench changes every input on a falling clock edge and reads the outputs on the next falling edge, which sits half a cycle after the updating edge. For the hold checks, it samples after a full frame has been shifted but before sel_ld rises, and again after ignored serial-clock activity. In both cases the outputs must still carry the earlier values.

// File: rtl/dac_span_pkg.sv
package dac_span_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    SPAN_UNI10 = 2'd0,
    SPAN_BIP5  = 2'd1,
    SPAN_BIP10 = 2'd2
  } span_t;

  localparam logic [CMD_W-1:0] CMD_SET_UNI10 = 4'b1001;
  localparam logic [CMD_W-1:0] CMD_SET_BIP5  = 4'b1010;
  localparam logic [CMD_W-1:0] CMD_SET_BIP10 = 4'b1011;
  localparam logic [CMD_W-1:0] CMD_CODE_ONLY = 4'b0010;

  // Bottom of each span in millivolts
  function automatic logic signed [15:0] span_floor_mv(input span_t s);
    case (s)
      SPAN_BIP5:  span_floor_mv = -16'sd5000;
      SPAN_BIP10: span_floor_mv = -16'sd10000;
      default:    span_floor_mv = 16'sd0;
    endcase
  endfunction

  // Full width of each span in millivolts
  function automatic logic [15:0] span_width_mv(input span_t s);
    case (s)
      SPAN_BIP10: span_width_mv = 16'd20000;
      default:    span_width_mv = 16'd10000;
    endcase
  endfunction

endpackage

// File: rtl/dac_span_shifter.sv
module dac_span_shifter
  import dac_span_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int PAD_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              sel_ld,
  output logic              load_evt,
  output logic              frame_full,
  output logic [CMD_W-1:0]  frame_cmd,
  output logic [CODE_W-1:0] frame_code
);
  localparam int FRAME_W = CMD_W + PAD_W + CODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic               sclk_q, sel_q;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               shift_en;

  always_comb begin
    shift_en = ser_clk & ~sclk_q & ~sel_ld;
    load_evt = sel_ld & ~sel_q;
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    if (shift_en) begin
      shreg_d = {shreg_q[FRAME_W-2:0], ser_dat};
      if (cnt_q != FULL_CNT) cnt_d = cnt_q + 1'b1;
    end
    if (sel_ld) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sel_q   <= 1'b1;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q <= ser_clk;
      sel_q  <= sel_ld;
      if (shift_en) shreg_q <= shreg_d;
      if (shift_en || sel_ld) cnt_q <= cnt_d;
    end
  end

  assign frame_full = (cnt_q == FULL_CNT);
  assign frame_cmd  = shreg_q[FRAME_W-1 -: CMD_W];
  assign frame_code = shreg_q[CODE_W-1:0];

endmodule

// File: rtl/dac_span_regs.sv
module dac_span_regs
  import dac_span_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              frame_full,
  input  logic [CMD_W-1:0]  frame_cmd,
  input  logic [CODE_W-1:0] frame_code,
  output span_t             span_q,
  output logic [CODE_W-1:0] code_q
);
  span_t             span_d;
  logic [CODE_W-1:0] code_d;
  logic              take_code;

  always_comb begin
    span_d    = span_q;
    code_d    = code_q;
    take_code = 1'b0;
    if (load_evt && frame_full) begin
      case (frame_cmd)
        CMD_SET_UNI10: begin span_d = SPAN_UNI10; take_code = 1'b1; end
        CMD_SET_BIP5:  begin span_d = SPAN_BIP5;  take_code = 1'b1; end
        CMD_SET_BIP10: begin span_d = SPAN_BIP10; take_code = 1'b1; end
        CMD_CODE_ONLY: take_code = 1'b1;
        default:       take_code = 1'b0;
      endcase
    end
    if (take_code) code_d = frame_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= SPAN_UNI10;
      code_q <= '0;
    end else if (load_evt) begin
      span_q <= span_d;
      code_q <= code_d;
    end
  end

endmodule

// File: rtl/dac_span_scale.sv
module dac_span_scale
  import dac_span_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int MV_W   = 16
) (
  input  span_t             span,
  input  logic [CODE_W-1:0] code,
  output logic [MV_W-1:0]   mv
);
  localparam int PW = CODE_W + 16;

  logic [15:0]        width;
  logic signed [15:0] floor_mv;
  logic [PW-1:0]      prod, scaled;
  logic signed [PW-1:0] sum;

  always_comb begin
    width    = span_width_mv(span);
    floor_mv = span_floor_mv(span);
    prod     = {{16{1'b0}}, code} * {{CODE_W{1'b0}}, width};
    scaled   = prod >> CODE_W;
    sum      = $signed(scaled) + $signed({{CODE_W{floor_mv[15]}}, floor_mv});
    mv       = sum[MV_W-1:0];
  end

endmodule

// File: rtl/dac_span_loader.sv
module dac_span_loader
  import dac_span_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int PAD_W  = 4,
  parameter int MV_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              sel_ld,
  output logic [CODE_W-1:0] dac_code,
  output logic [1:0]        span_sel,
  output logic [MV_W-1:0]   ideal_mv
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              load_evt, frame_full;
  logic [CMD_W-1:0]  frame_cmd;
  logic [CODE_W-1:0] frame_code;
  span_t             span_q;
  logic [CODE_W-1:0] code_q;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  dac_span_shifter #(.CODE_W(CODE_W), .PAD_W(PAD_W)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .sel_ld(sel_ld), .load_evt(load_evt), .frame_full(frame_full),
    .frame_cmd(frame_cmd), .frame_code(frame_code)
  );

  dac_span_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .load_evt(load_evt),
    .frame_full(frame_full), .frame_cmd(frame_cmd), .frame_code(frame_code),
    .span_q(span_q), .code_q(code_q)
  );

  dac_span_scale #(.CODE_W(CODE_W), .MV_W(MV_W)) u_scale (
    .span(span_q), .code(code_q), .mv(ideal_mv)
  );

  assign dac_code = code_q;
  assign span_sel = span_q;

endmodule

// File: rtl/dac_span_loader_chk.sv
module dac_span_loader_chk
  import dac_span_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int MV_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_ld,
  input logic              load_evt,
  input logic              frame_full,
  input logic [CMD_W-1:0]  frame_cmd,
  input logic [CODE_W-1:0] frame_code,
  input logic [CODE_W-1:0] dac_code,
  input logic [1:0]        span_sel,
  input logic [MV_W-1:0]   ideal_mv
);
  logic good_frame, known_cmd;
  assign good_frame = load_evt && frame_full;
  assign known_cmd  = (frame_cmd == CMD_SET_UNI10) || (frame_cmd == CMD_SET_BIP5) ||
                      (frame_cmd == CMD_SET_BIP10) || (frame_cmd == CMD_CODE_ONLY);

  a_r4_hold_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_ld |=> ($stable(dac_code) && $stable(span_sel)));

  a_r5_unipolar_load: assert property (@(posedge clk) disable iff (!rst_n)
    (good_frame && frame_cmd == CMD_SET_UNI10) |=>
      (span_sel == 2'd0 && dac_code == $past(frame_code)));

  a_r6_bip5_load: assert property (@(posedge clk) disable iff (!rst_n)
    (good_frame && frame_cmd == CMD_SET_BIP5) |=>
      (span_sel == 2'd1 && dac_code == $past(frame_code)));

  a_r7_bip10_load: assert property (@(posedge clk) disable iff (!rst_n)
    (good_frame && frame_cmd == CMD_SET_BIP10) |=>
      (span_sel == 2'd2 && dac_code == $past(frame_code)));

  a_r8_code_keeps_span: assert property (@(posedge clk) disable iff (!rst_n)
    (good_frame && frame_cmd == CMD_CODE_ONLY) |=>
      ($stable(span_sel) && dac_code == $past(frame_code)));

  a_r9_unknown_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (good_frame && !known_cmd) |=> ($stable(span_sel) && $stable(dac_code)));

  a_r10_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !frame_full) |=> ($stable(span_sel) && $stable(dac_code)));

  a_r12_mv_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed(ideal_mv) >= -10000) && ($signed(ideal_mv) <= 10000) && (span_sel != 2'd3));

endmodule

bind dac_span_loader dac_span_loader_chk #(.CODE_W(CODE_W), .MV_W(MV_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .sel_ld(sel_ld), .load_evt(load_evt),
  .frame_full(frame_full), .frame_cmd(frame_cmd), .frame_code(frame_code),
  .dac_code(dac_code), .span_sel(span_sel), .ideal_mv(ideal_mv)
);

// File: tb/dac_span_loader_bench.sv
module dac_span_loader_bench;
  logic        clk = 1'b0;
  logic        rst_n, ser_clk, ser_dat, sel_ld;
  logic [15:0] dac_code;
  logic [1:0]  span_sel;
  logic [15:0] ideal_mv;
  int total = 0;
  int bad   = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dac_span_loader u_dac_span_loader (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .sel_ld(sel_ld), .dac_code(dac_code), .span_sel(span_sel), .ideal_mv(ideal_mv)
  );

  function automatic int exp_mv(input int sp, input int code);
    case (sp)
      1:       exp_mv = (code * 10000) / 65536 - 5000;
      2:       exp_mv = (code * 20000) / 65536 - 10000;
      default: exp_mv = (code * 10000) / 65536;
    endcase
  endfunction

  task automatic chk(input string req, input int sp, input int code);
    int got_mv;
    got_mv = int'($signed(ideal_mv));
    total++;
    if (dac_code !== 16'(code) || span_sel !== 2'(sp) || got_mv != exp_mv(sp, code)) begin
      bad++;
      $display("FAIL %s: code=%h span=%0d mv=%0d expected code=%h span=%0d mv=%0d",
               req, dac_code, span_sel, got_mv, 16'(code), sp, exp_mv(sp, code));
    end
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    @(negedge clk) sel_ld = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); ser_dat = bits[i]; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
  endtask

  task automatic close_frame();
    @(negedge clk) sel_ld = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 reset", 0, 16'h0000);
  endtask

  task automatic t_unipolar();
    shift_bits(32'h009A_0000, 24);
    close_frame();
    chk("R5 unipolar zero", 0, 16'h0000);
    shift_bits(32'h0090_FFFF, 24);
    chk("R4 hold before load", 0, 16'h0000);
    close_frame();
    chk("R2 R12 unipolar full", 0, 16'hFFFF);
    shift_bits(32'h0095_8000, 24);
    close_frame();
    chk("R12 unipolar mid", 0, 16'h8000);
  endtask

  task automatic t_bip5();
    shift_bits(32'h00A0_8000, 24);
    close_frame();
    chk("R6 bip5 zero", 1, 16'h8000);
    shift_bits(32'h00AF_FFFF, 24);
    close_frame();
    chk("R12 bip5 top", 1, 16'hFFFF);
  endtask

  task automatic t_bip10_long();
    shift_bits(32'h9AB0_C000, 32);
    close_frame();
    chk("R3 R7 32-bit bip10", 2, 16'hC000);
    shift_bits(32'hB020_4000, 32);
    close_frame();
    chk("R3 R8 32-bit code only", 2, 16'h4000);
  endtask

  task automatic t_keep();
    shift_bits(32'h0020_0000, 24);
    close_frame();
    chk("R8 R12 bip10 bottom", 2, 16'h0000);
  endtask

  task automatic t_bad_cmd();
    shift_bits(32'h0070_1234, 24);
    close_frame();
    chk("R9 cmd 0111", 2, 16'h0000);
    shift_bits(32'h0000_5555, 24);
    close_frame();
    chk("R9 cmd 0000", 2, 16'h0000);
  endtask

  task automatic t_short();
    shift_bits(32'h0000_9012, 16);
    close_frame();
    chk("R10 16-bit frame", 2, 16'h0000);
    shift_bits(32'h0009_0ABC, 23);
    close_frame();
    chk("R10 23-bit frame", 2, 16'h0000);
  endtask

  task automatic t_idle_clk();
    @(negedge clk) sel_ld = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); ser_dat = 1'b1; ser_clk = 1'b1;
      @(negedge clk); ser_clk = 1'b0;
    end
    chk("R11 edges while deselected", 2, 16'h0000);
    shift_bits(32'h0000_1111, 16);
    close_frame();
    chk("R11 no carry-over count", 2, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; sel_ld = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unipolar();
    t_bip5();
    t_bip10_long();
    t_keep();
    t_bad_cmd();
    t_short();
    t_idle_clk();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      total++;
      bad++;
      finished = 1;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule